// File: doc/BRIEF.md
# Masked Lowest-Bit Manipulation Unit

This unit carries out the family of lowest-set-bit and lowest-clear-bit idioms (isolate, clear, set, or build a mask up to the lowest one or zero) inside an arbitrary bit-field mask. An XLEN-bit source is first restricted by a mask operand. A mask selector of zero replaces that operand with all ones. Two intermediate terms are derived from the restricted source. A 5-bit operation field picks whether the first term is inverted, which of four arithmetic forms gives the second term, and which bitwise operator combines them.

The combined value is confined to the mask once more. A restore flag can merge the source bits that lie outside the mask back into the result. This lets a field be edited in place.

The datapath is combinational, with one output register. A request presented with `in_valid` produces its result on the next clock edge, together with a one-cycle `out_valid` pulse. The operator code that has no defined meaning yields zero and raises a flag.

Top module: `lowbit_mask_unit`

## Requirements
- R1: When `mask_idx` is zero the working mask is all ones and `mask_b` has no effect on the result. Otherwise the working mask equals `mask_b`.
- R2: The working value is `ra = src_a & mask`. The first term is `ra` when `op_field[0]` is 1 and `~ra` when it is 0. The field is numbered big-endian, so this is field bit 4.
- R3: The second term is chosen by the 2-bit code `{op_field[2], op_field[1]}`, all arithmetic modulo 2^XLEN:
  - 0 gives `(~ra)+1`
  - 1 gives `ra-1`
  - 2 gives `ra+1`
  - 3 gives `~(ra+1)`
- R4: Both terms are ANDed with the mask and then combined by the code `{op_field[4], op_field[3]}`: 0 is OR, 1 is AND, 2 is XOR. The combined value is ANDed with the mask again.
- R5: With `restore` at 1, result bits outside the mask equal the matching `src_a` bits. With `restore` at 0 they are zero.
- R6: Operator code 3 gives an all-zero result, whatever `restore` is, and sets `reserved_op` to 1. Every other code sets `reserved_op` to 0.
- R7: A request sampled with `in_valid` high at a clock edge appears on `result` and `reserved_op` after that edge. `out_valid` is high for exactly that cycle.
- R8: While `in_valid` is low, `result` and `reserved_op` keep their values and `out_valid` is 0.
- R9: While `rst_ni` is low, `out_valid`, `result` and `reserved_op` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | XLEN | Source operand |
| mask_b | input | XLEN | Mask operand |
| mask_idx | input | SEL_W | Mask selector; zero means all ones |
| op_field | input | 5 | Operation field: [0] term-one polarity, [2:1] second-term form, [4:3] operator |
| restore | input | 1 | Merge unmasked source bits back |
| out_valid | output | 1 | Result valid pulse |
| result | output | XLEN | Registered result |
| reserved_op | output | 1 | Undefined operator code was used |

## Verification
The clocked properties take for granted that every request input is known and stable across the capturing edge. They compare each registered output with the operands held one cycle earlier. The bench meets this by driving all inputs on the falling edge and holding them through the following rising edge. It drops `in_valid` before the next rising edge, and it changes operands while `in_valid` is low only to show that they are ignored.

// File: rtl/lmu_pkg.sv
package lmu_pkg;

   typedef enum logic [1:0] {
      T2_NEG  = 2'd0,
      T2_DEC  = 2'd1,
      T2_INC  = 2'd2,
      T2_NINC = 2'd3
   } term2_form_e;

   typedef enum logic [1:0] {
      CMB_OR   = 2'd0,
      CMB_AND  = 2'd1,
      CMB_XOR  = 2'd2,
      CMB_RSVD = 2'd3
   } comb_op_e;

   typedef struct packed {
      logic        keep_ra;
      term2_form_e form;
      comb_op_e    comb;
   } op_dec_t;

   // Field bit 0 (big-endian) is port bit 4.
   function automatic op_dec_t decode_op(input logic [4:0] f);
      op_dec_t d;
      d.keep_ra = f[0];
      d.form    = term2_form_e'({f[2], f[1]});
      d.comb    = comb_op_e'({f[4], f[3]});
      return d;
   endfunction

endpackage

// File: rtl/lmu_mask_gen.sv
module lmu_mask_gen #(
   parameter int XLEN  = 64,
   parameter int SEL_W = 5
) (
   input  logic [XLEN-1:0]  src_a,
   input  logic [XLEN-1:0]  mask_b,
   input  logic [SEL_W-1:0] mask_idx,
   output logic [XLEN-1:0]  mask,
   output logic [XLEN-1:0]  ra
);
   localparam logic [SEL_W-1:0] SEL_NONE = '0;

   always_comb begin
      mask = (mask_idx == SEL_NONE) ? {XLEN{1'b1}} : mask_b;
      ra   = src_a & mask;
   end
endmodule

// File: rtl/lmu_terms.sv
module lmu_terms
   import lmu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] ra,
   input  logic [XLEN-1:0] mask,
   input  logic            keep_ra,
   input  term2_form_e     form,
   output logic [XLEN-1:0] term1,
   output logic [XLEN-1:0] term2
);
   localparam logic [XLEN-1:0] ONE = XLEN'(1);

   logic [XLEN-1:0] inc_ra;
   logic [XLEN-1:0] raw2;

   assign inc_ra = ra + ONE;

   always_comb begin
      unique case (form)
         T2_NEG:  raw2 = (~ra) + ONE;
         T2_DEC:  raw2 = ra - ONE;
         T2_INC:  raw2 = inc_ra;
         default: raw2 = ~inc_ra;
      endcase
      term1 = (keep_ra ? ra : ~ra) & mask;
      term2 = raw2 & mask;
   end
endmodule

// File: rtl/lmu_combine.sv
module lmu_combine
   import lmu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] term1,
   input  logic [XLEN-1:0] term2,
   input  logic [XLEN-1:0] mask,
   input  logic [XLEN-1:0] src_a,
   input  logic            restore,
   input  comb_op_e        comb,
   output logic [XLEN-1:0] value,
   output logic            reserved
);
   logic [XLEN-1:0] merged;

   always_comb begin
      reserved = 1'b0;
      unique case (comb)
         CMB_OR:  merged = term1 | term2;
         CMB_AND: merged = term1 & term2;
         CMB_XOR: merged = term1 ^ term2;
         default: begin
            merged   = '0;
            reserved = 1'b1;
         end
      endcase
      merged = merged & mask;
      if (restore && !reserved) begin
         merged = merged | (src_a & ~mask);
      end
      value = merged;
   end
endmodule

// File: rtl/lowbit_mask_unit.sv
module lowbit_mask_unit
   import lmu_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int SEL_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             in_valid,
   input  logic [XLEN-1:0]  src_a,
   input  logic [XLEN-1:0]  mask_b,
   input  logic [SEL_W-1:0] mask_idx,
   input  logic [4:0]       op_field,
   input  logic             restore,
   output logic             out_valid,
   output logic [XLEN-1:0]  result,
   output logic             reserved_op
);
   generate
      if (XLEN < 2) begin : g_bad_xlen
         $error("lowbit_mask_unit: XLEN must be at least 2");
      end
      if (SEL_W < 1) begin : g_bad_sel
         $error("lowbit_mask_unit: SEL_W must be at least 1");
      end
   endgenerate

   op_dec_t         dec;
   logic [XLEN-1:0] mask;
   logic [XLEN-1:0] ra;
   logic [XLEN-1:0] term1;
   logic [XLEN-1:0] term2;
   logic [XLEN-1:0] value_d;
   logic            rsvd_d;

   assign dec = decode_op(op_field);

   lmu_mask_gen #(.XLEN(XLEN), .SEL_W(SEL_W)) u_mask (
      .src_a    (src_a),
      .mask_b   (mask_b),
      .mask_idx (mask_idx),
      .mask     (mask),
      .ra       (ra)
   );

   lmu_terms #(.XLEN(XLEN)) u_terms (
      .ra      (ra),
      .mask    (mask),
      .keep_ra (dec.keep_ra),
      .form    (dec.form),
      .term1   (term1),
      .term2   (term2)
   );

   lmu_combine #(.XLEN(XLEN)) u_comb (
      .term1    (term1),
      .term2    (term2),
      .mask     (mask),
      .src_a    (src_a),
      .restore  (restore),
      .comb     (dec.comb),
      .value    (value_d),
      .reserved (rsvd_d)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         out_valid   <= 1'b0;
         result      <= '0;
         reserved_op <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result      <= value_d;
            reserved_op <= rsvd_d;
         end
      end
   end
endmodule

// File: rtl/lmu_checker.sv
module lmu_checker #(
   parameter int XLEN  = 64,
   parameter int SEL_W = 5
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             in_valid,
   input logic [XLEN-1:0]  src_a,
   input logic [XLEN-1:0]  mask_b,
   input logic [SEL_W-1:0] mask_idx,
   input logic [4:0]       op_field,
   input logic             restore,
   input logic             out_valid,
   input logic [XLEN-1:0]  result,
   input logic             reserved_op
);
   // R7: a sampled request yields exactly one valid cycle
   a_r7_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid |=> out_valid);
   a_r8_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid |=> !out_valid);

   // R8: outputs hold between requests
   a_r8_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid |=> ($stable(result) && $stable(reserved_op)));

   // R6: undefined operator gives zero and raises the flag
   a_r6_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid && op_field[4:3] == 2'b11) |=> (reserved_op && result == '0));
   a_r6_defined_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid && op_field[4:3] != 2'b11) |=> !reserved_op);

   // R5: bits outside an explicit mask are source bits or zero
   a_r5_outside_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid && op_field[4:3] != 2'b11 && mask_idx != '0) |=>
      ((result & ~$past(mask_b)) ==
       ($past(restore) ? ($past(src_a) & ~$past(mask_b)) : '0)));

   // R9: reset state of the outputs
   a_r9_reset_state: assert property (@(posedge clk_i)
      !rst_ni |=> (!out_valid && !reserved_op && result == '0));
endmodule

bind lowbit_mask_unit lmu_checker #(.XLEN(XLEN), .SEL_W(SEL_W)) u_lmu_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .in_valid    (in_valid),
   .src_a       (src_a),
   .mask_b      (mask_b),
   .mask_idx    (mask_idx),
   .op_field    (op_field),
   .restore     (restore),
   .out_valid   (out_valid),
   .result      (result),
   .reserved_op (reserved_op)
);

// File: tb/tb_lowbit_mask_unit.sv
module tb_lowbit_mask_unit;
   localparam int XLEN  = 64;
   localparam int SEL_W = 5;
   localparam int NVEC  = 12;
   localparam int LIMIT = 5000;

   typedef struct packed {
      logic [XLEN-1:0]  src;
      logic [XLEN-1:0]  msk;
      logic [SEL_W-1:0] sel;
      logic [4:0]       op;
      logic             rst;
      logic [XLEN-1:0]  exp;
      logic             rsv;
   } vec_t;

   // op = {comb[1:0], form[1:0], keep_ra}
   localparam vec_t VEC [NVEC] = '{
      '{64'h58,   64'h0,   5'd0, 5'b01001, 1'b0, 64'h08, 1'b0},                   // R2 isolate lowest set
      '{64'h58,   64'h0,   5'd0, 5'b01011, 1'b0, 64'h50, 1'b0},                   // R3 clear lowest set
      '{64'h58,   64'h0,   5'd0, 5'b10011, 1'b0, 64'h0F, 1'b0},                   // R4 mask up to lowest set
      '{64'h57,   64'h0,   5'd0, 5'b00101, 1'b0, 64'h5F, 1'b0},                   // R4 set lowest clear
      '{64'h57,   64'h0,   5'd0, 5'b01100, 1'b0, 64'h08, 1'b0},                   // R2 isolate lowest clear
      '{64'h0,    64'h0,   5'd0, 5'b00110, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},  // R3 form 3
      '{64'hFF38, 64'hF0,  5'd3, 5'b01001, 1'b0, 64'h10, 1'b0},                   // R5 masked, no restore
      '{64'hFF38, 64'hF0,  5'd3, 5'b01001, 1'b1, 64'hFF18, 1'b0},                 // R5 masked, restore
      '{64'hFF38, 64'hF0,  5'd3, 5'b11001, 1'b1, 64'h0, 1'b1},                    // R6 reserved
      '{64'h1234, 64'h0,   5'd1, 5'b01001, 1'b1, 64'h1234, 1'b0},                 // R5 empty mask
      '{64'h8000_0000_0000_0000, 64'hFF, 5'd0, 5'b01001, 1'b0,
        64'h8000_0000_0000_0000, 1'b0},                                           // R1 selector zero
      '{64'h0,    64'h0,   5'd0, 5'b10011, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}   // R3 decrement wrap
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             in_valid;
   logic [XLEN-1:0]  src_a;
   logic [XLEN-1:0]  mask_b;
   logic [SEL_W-1:0] mask_idx;
   logic [4:0]       op_field;
   logic             restore;
   logic             out_valid;
   logic [XLEN-1:0]  result;
   logic             reserved_op;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   lowbit_mask_unit #(.XLEN(XLEN), .SEL_W(SEL_W)) dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .in_valid    (in_valid),
      .src_a       (src_a),
      .mask_b      (mask_b),
      .mask_idx    (mask_idx),
      .op_field    (op_field),
      .restore     (restore),
      .out_valid   (out_valid),
      .result      (result),
      .reserved_op (reserved_op)
   );

   function automatic string vec_tag(input int i);
      case (i)
         0, 4:       return "R2";
         1, 5, 11:   return "R3";
         2, 3:       return "R4";
         6, 7, 9:    return "R5";
         8:          return "R6";
         default:    return "R1";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [XLEN-1:0] s, input logic [XLEN-1:0] m,
                        input logic [SEL_W-1:0] sel, input logic [4:0] op, input logic r);
      in_valid = v;
      src_a    = s;
      mask_b   = m;
      mask_idx = sel;
      op_field = op;
      restore  = r;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > LIMIT && !done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      drive(1'b0, '0, '0, '0, 5'b0, 1'b0);
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", "out_valid in reset", XLEN'(out_valid), '0);
      check("R9", "result in reset", result, '0);
      check("R9", "reserved_op in reset", XLEN'(reserved_op), '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         drive(1'b1, VEC[i].src, VEC[i].msk, VEC[i].sel, VEC[i].op, VEC[i].rst);
         @(negedge clk);
         in_valid = 1'b0;
         check(vec_tag(i), $sformatf("result vec %0d", i), result, VEC[i].exp);
         check("R6", $sformatf("reserved_op vec %0d", i), XLEN'(reserved_op), XLEN'(VEC[i].rsv));
         check("R7", $sformatf("out_valid vec %0d", i), XLEN'(out_valid), 1);
         @(negedge clk);
         check("R7", $sformatf("out_valid drop vec %0d", i), XLEN'(out_valid), 0);
      end

      // R8: operands change with in_valid low; last result (all ones) must hold
      drive(1'b0, 64'h58, 64'h0, 5'd0, 5'b11001, 1'b1);
      repeat (2) @(negedge clk);
      check("R8", "result hold", result, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R8", "reserved_op hold", XLEN'(reserved_op), 0);
      check("R8", "out_valid idle", XLEN'(out_valid), 0);

      // R6: reserved code with full mask and restore still gives zero
      drive(1'b1, 64'hDEAD_BEEF, 64'h0, 5'd0, 5'b11111, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      check("R6", "reserved full mask", result, '0);
      check("R6", "reserved flag full mask", XLEN'(reserved_op), 1);

      // R1: non-zero selector with all-ones mask matches selector zero
      drive(1'b1, 64'h0F00, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, 5'b01001, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      check("R1", "explicit full mask", result, 64'h0100);

      // R9: reset after activity clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R9", "result after reset", result, '0);
      check("R9", "out_valid after reset", XLEN'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule